// File: doc/BRIEF.md
# Quad-I/O Serial Flash Read Target

This block is the device side of a serial flash that serves one read command: a fast read in which the address, a mode byte and the returned data all travel over four data lines at once. A host lowers chip select, clocks in an 8-bit command on data line 0, then a 24-bit address and a mode byte as nibbles on all four lines. After four idle clocks the block returns bytes from a small internal array, four bits per clock, and keeps doing so while the host keeps clocking. The block is clocked by a fast system clock `clk_i` and finds the serial clock edges by oversampling `sck_i`. Inputs are sampled on serial-clock rising edges and outputs change on falling edges.

The mode byte can shorten later reads. When its upper nibble is `0xA`, the block enters a continuous state. In that state the next chip-select cycle starts directly with the address, which saves the eight command clocks. Any other upper nibble leaves the state. A separate mode-reset input also clears it. The array is loaded through a parallel write port. The read command is accepted only while the quad-enable input is high.

Top module: `qspi_rd_target`

## Requirements
- R1: In normal state, the first 8 rising edges after chip select falls shift `io_i[0]` MSB first. The read proceeds only if the byte equals `0xEB` and `quad_en_i` is high.
- R2: The address is taken over 6 rising edges as nibbles on `io_i[3:0]`, most significant nibble first. The low `$clog2(MEM_BYTES)` bits select the array byte.
- R3: Two mode nibbles follow the address. An upper nibble of `0xA` sets the continuous state, any other value clears it, and the lower nibble has no effect.
- R4: Four dummy clocks follow the mode byte. `io_oe_o` stays 0 through the command, address, mode and dummy phases.
- R5: Data nibbles change only on serial-clock falling edges, high nibble of each byte first. During data, `io_oe_o` is `4'hF`, and in all other phases it is `4'h0`. `io_i` is ignored during data.
- R6: The read address advances after every byte and wraps from `MEM_BYTES-1` to 0.
- R7: In the continuous state, the next chip-select cycle starts with the address, with no command byte.
- R8: With `quad_en_i` low, a transaction drives nothing and leaves the continuous state unchanged.
- R9: A command byte other than `0xEB` makes the block ignore the rest of that chip-select cycle, with outputs left released.
- R10: A `mode_rst_i` pulse clears the continuous state, so the next cycle expects a command byte.
- R11: Raising chip select releases `io_oe_o` on the next `clk_i` edge and restarts the sequencing, but keeps the continuous state. The reset state has outputs released and normal state.
- R12: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, idles low |
| io_i | input | 4 | Data lines, input side |
| io_o | output | 4 | Data lines, output side |
| io_oe_o | output | 4 | Output enable per data line |
| quad_en_i | input | 1 | Quad-enable configuration bit |
| mode_rst_i | input | 1 | Pulse that clears the continuous state |
| wr_en_i | input | 1 | Array write strobe |
| wr_addr_i | input | AW | Array write address |
| wr_data_i | input | 8 | Array write data |

## Verification
The hardest situations to reach are the ones where the continuous state must survive events that reset everything else. Examples are an abort in mid-data and a transaction refused because quad-enable is low. After such an event, the next cycle has to start with the address. The stimulus first arms the continuous state with an `0xA` mode nibble, then causes the event. It then sends an address with no command byte and compares the returned bytes. After a mode reset, the same address-first sequence must be refused, and a command-first read must be decoded again. A stale flag or a lost flag therefore shows up as wrong data or as lines left released.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  localparam logic [7:0] CMD_QREAD = 8'hEB;
  localparam logic [3:0] CONT_NIB  = 4'hA;
  localparam int unsigned ADDR_NIBS  = 6;
  localparam int unsigned MODE_NIBS  = 2;
  localparam int unsigned DUMMY_CLKS = 4;
  localparam int unsigned CMD_BITS   = 8;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } seq_state_e;
endpackage

// File: rtl/qspi_rd_edge.sv
module qspi_rd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/qspi_rd_mem.sv
module qspi_rd_mem #(
  parameter int unsigned MEM_BYTES = 256,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [MEM_BYTES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/qspi_rd_seq.sv
module qspi_rd_seq
  import qspi_rd_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 256,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [3:0]    io_i,
  input  logic          quad_en_i,
  input  logic          mode_rst_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [3:0]    io_o,
  output logic          oe_o,
  output logic          cont_o
);
  seq_state_e state_q;
  logic [2:0] cnt_q;
  logic [6:0] cmd_q;
  logic [3:0] mode_hi_q;
  logic       lo_nib_q;
  logic       cont_q;
  logic [AW-1:0] addr_q;
  logic [7:0] cmd_full;

  assign cmd_full = {cmd_q, io_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CMD;
      cnt_q     <= '0;
      cmd_q     <= '0;
      mode_hi_q <= '0;
      lo_nib_q  <= 1'b0;
      cont_q    <= 1'b0;
      addr_q    <= '0;
      io_o      <= '0;
      oe_o      <= 1'b0;
    end else begin
      if (cs_ni) begin
        state_q  <= (cont_q && quad_en_i) ? ST_ADDR : ST_CMD;
        cnt_q    <= '0;
        lo_nib_q <= 1'b0;
        oe_o     <= 1'b0;
      end else if (rise_i) begin
        unique case (state_q)
          ST_CMD: begin
            cmd_q <= cmd_full[6:0];
            if (cnt_q == 3'(CMD_BITS - 1)) begin
              cnt_q   <= '0;
              state_q <= (cmd_full == CMD_QREAD && quad_en_i) ? ST_ADDR : ST_IGNORE;
            end else begin
              cnt_q <= cnt_q + 3'd1;
            end
          end
          ST_ADDR: begin
            // only the low AW bits survive the shift
            addr_q <= {addr_q[AW-5:0], io_i};
            if (cnt_q == 3'(ADDR_NIBS - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_MODE;
            end else begin
              cnt_q <= cnt_q + 3'd1;
            end
          end
          ST_MODE: begin
            if (cnt_q == 3'd0) begin
              mode_hi_q <= io_i;
              cnt_q     <= cnt_q + 3'd1;
            end else begin
              cont_q  <= (mode_hi_q == CONT_NIB);
              cnt_q   <= '0;
              state_q <= ST_DUMMY;
            end
          end
          ST_DUMMY: begin
            if (cnt_q == 3'(DUMMY_CLKS - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_DATA;
            end else begin
              cnt_q <= cnt_q + 3'd1;
            end
          end
          default: ;
        endcase
      end else if (fall_i && state_q == ST_DATA) begin
        io_o     <= lo_nib_q ? rd_data_i[3:0] : rd_data_i[7:4];
        oe_o     <= 1'b1;
        lo_nib_q <= ~lo_nib_q;
        if (lo_nib_q) addr_q <= addr_q + AW'(1);
      end
      if (mode_rst_i) cont_q <= 1'b0;
    end
  end

  assign rd_addr_o = addr_q;
  assign cont_o    = cont_q;
endmodule

// File: rtl/qspi_rd_target.sv
module qspi_rd_target #(
  parameter int unsigned MEM_BYTES = 256,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sck_i,
  input  logic [3:0]    io_i,
  output logic [3:0]    io_o,
  output logic [3:0]    io_oe_o,
  input  logic          quad_en_i,
  input  logic          mode_rst_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i
);
  logic          rise_w, fall_w, oe_w, cont_w;
  logic [AW-1:0] rd_addr_w;
  logic [7:0]    rd_data_w;

  qspi_rd_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  qspi_rd_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_w),
    .rd_data_o (rd_data_w)
  );

  qspi_rd_seq #(.MEM_BYTES(MEM_BYTES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .io_i       (io_i),
    .quad_en_i  (quad_en_i),
    .mode_rst_i (mode_rst_i),
    .rd_data_i  (rd_data_w),
    .rd_addr_o  (rd_addr_w),
    .io_o       (io_o),
    .oe_o       (oe_w),
    .cont_o     (cont_w)
  );

  assign io_oe_o = {4{oe_w}};
endmodule

// File: rtl/qspi_rd_target_chk.sv
module qspi_rd_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sck_i,
  input logic       mode_rst_i,
  input logic [3:0] io_o,
  input logic [3:0] io_oe_o,
  input logic       cont_i
);
  p_release_on_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (io_oe_o == 4'h0));

  p_oe_all_or_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 4'h0) || (io_oe_o == 4'hF));

  p_data_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(io_o) |-> ($past(sck_i, 2) && !$past(sck_i)));

  p_mode_rst_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_rst_i |=> !cont_i);

  p_cont_kept_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !mode_rst_i) |=> (cont_i == $past(cont_i)));
endmodule

bind qspi_rd_target qspi_rd_target_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .sck_i      (sck_i),
  .mode_rst_i (mode_rst_i),
  .io_o       (io_o),
  .io_oe_o    (io_oe_o),
  .cont_i     (cont_w)
);

// File: tb/qspi_rd_target_test.sv
module qspi_rd_target_test;
  localparam int MB = 256;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0;
  logic [3:0] io_in = '0;
  logic [3:0] io_out, io_oe;
  logic qe = 1'b1, mrst = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] mdl [MB];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qspi_rd_target #(.MEM_BYTES(MB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck),
    .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe),
    .quad_en_i(qe), .mode_rst_i(mrst),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one serial clock: low phase (falling edge), sample, then rising edge
  task automatic tick(input logic [3:0] nib, output logic [3:0] got, output logic [3:0] oe);
    @(negedge clk); sck = 1'b0; io_in = nib;
    @(negedge clk); @(negedge clk);
    got = io_out; oe = io_oe;
    sck = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk); sck = 1'b0; cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk); sck = 1'b0; cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic [3:0] g, oe;
    for (int i = 7; i >= 0; i--) begin
      tick({3'b0, c[i]}, g, oe);
      chk(oe == 4'h0, "R4 cmd phase released", oe, 0);
    end
  endtask

  task automatic send_hdr(input logic [23:0] a, input logic [7:0] m);
    logic [3:0] g, oe;
    for (int i = 5; i >= 0; i--) begin
      tick(a[i*4 +: 4], g, oe);
      chk(oe == 4'h0, "R4 addr phase released", oe, 0);
    end
    tick(m[7:4], g, oe);
    tick(m[3:0], g, oe);
    for (int i = 0; i < 4; i++) begin
      tick(4'h0, g, oe);
      chk(oe == 4'h0, "R4 dummy phase released", oe, 0);
    end
  endtask

  task automatic read_chk(input int a, input int n, input string req);
    logic [3:0] hi, lo, oe1, oe2;
    for (int i = 0; i < n; i++) begin
      tick(4'h5, hi, oe1);
      tick(4'hA, lo, oe2);
      chk({hi, lo} == mdl[(a + i) % MB] && oe1 == 4'hF && oe2 == 4'hF,
          req, {oe1, oe2, hi, lo}, {8'hFF, mdl[(a + i) % MB]});
    end
  endtask

  task automatic expect_idle(input int n, input string req);
    logic [3:0] g, oe;
    for (int i = 0; i < n; i++) begin
      tick(4'h0, g, oe);
      chk(oe == 4'h0, req, oe, 0);
    end
  endtask

  task automatic mem_wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    mdl[a] = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(io_oe == 4'h0, "R11 reset released", io_oe, 0);
    rst_n = 1'b1;
    for (int a = 0; a < MB; a++) mem_wr(a, 8'((a * 37 + 11) & 255));

    // R1 R2 R5 R6 R12: plain reads at several addresses
    for (int s = 0; s < 4; s++) begin
      cs_low(); send_cmd(8'hEB); send_hdr(24'h5A0010 + 24'(s * 61), 8'h3C);
      read_chk(16 + s * 61, 4, "R1 R2 R6 plain read"); cs_high();
    end
    // R2 R6: upper address bits dropped, wrap past top
    cs_low(); send_cmd(8'hEB); send_hdr(24'h1230FE, 8'h00);
    read_chk(254, 4, "R6 wrap"); cs_high();

    // R3 R7: arm continuous, lower nibble varied
    cs_low(); send_cmd(8'hEB); send_hdr(24'h000040, 8'hA5);
    read_chk(64, 2, "R3 arm"); cs_high();
    cs_low(); send_hdr(24'h000080, 8'hA0);
    read_chk(128, 3, "R7 address first"); cs_high();

    // R11: abort mid-data, flag kept
    cs_low(); send_hdr(24'h000020, 8'hAF);
    read_chk(32, 1, "R11 before abort");
    cs_high();
    chk(io_oe == 4'h0, "R11 abort releases", io_oe, 0);
    cs_low(); send_hdr(24'h000030, 8'h7A);
    read_chk(48, 2, "R11 flag kept after abort"); cs_high();

    // R3: non-A mode left continuous, address-first now is a bad command
    cs_low(); expect_idle(16, "R3 cleared by non-A mode"); cs_high();
    // R9: wrong command code
    cs_low(); send_cmd(8'h6B); send_hdr(24'h000010, 8'h00);
    expect_idle(4, "R9 wrong command ignored"); cs_high();

    // R8: quad disabled, continuous flag left untouched
    cs_low(); send_cmd(8'hEB); send_hdr(24'h000090, 8'hA1);
    read_chk(144, 1, "R8 arm"); cs_high();
    qe = 1'b0;
    cs_low(); send_cmd(8'hEB); send_hdr(24'h000010, 8'h00);
    expect_idle(4, "R8 quad off ignored"); cs_high();
    qe = 1'b1;
    cs_low(); send_hdr(24'h0000A0, 8'hA2);
    read_chk(160, 2, "R8 flag unchanged"); cs_high();

    // R10: mode reset returns to command decoding
    @(negedge clk); mrst = 1'b1; @(negedge clk); mrst = 1'b0;
    cs_low(); send_cmd(8'hEB); send_hdr(24'h0000C0, 8'h00);
    read_chk(192, 2, "R10 mode reset"); cs_high();

    // R12: side write then read back
    mem_wr(5, 8'h3C); mem_wr(6, 8'hC3);
    cs_low(); send_cmd(8'hEB); send_hdr(24'h000005, 8'h00);
    read_chk(5, 2, "R12 written data"); cs_high();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule